// File: doc/BRIEF.md
# Three-Byte-Instruction Register CPU Core

A small multicycle processor core that runs programs out of a byte-wide memory shared by code and data. It keeps four 16-bit general registers, a program counter, a single return-address register and two condition flags (zero and negative). Every instruction is three bytes: an opcode/register byte followed by a 16-bit operand address sent high byte first. Words in memory are big-endian: the high byte is at the operand address and the low byte at the next address up.

The core reads the three instruction bytes one per cycle over a synchronous memory port with a one-cycle read latency. It then either completes the instruction at once (control flow, halt) or makes two more byte accesses for the data word. The instruction set covers load, store, add-to-register, word output, call, return, jump, jump-if-zero and halt. An unknown opcode stops the core and raises an error line. After a halt or an error the core makes no further memory accesses until reset.

Top module: `tcpu_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the core requests a read at address START_ADDR (default 0x0010). Halted, error and out_valid are low and both flags are clear.
- R2: An instruction is fetched as three reads at PC, PC+1 and PC+2. The opcode is bits [7:4] of the first byte and the register index is bits [1:0]; bits [3:2] are ignored. Bytes two and three are the operand address, high byte first.
- R3: Opcode 0 (load) sets register = {mem[A], mem[A+1]} and then PC += 3.
- R4: Opcode 1 (store) writes the register's high byte to A and then its low byte to A+1 on two consecutive cycles, and PC += 3.
- R5: Opcode 4 (add) sets register = register + {mem[A], mem[A+1]} modulo 2^16, with the carry discarded, and PC += 3.
- R6: Opcode 2 (output) presents {mem[A], mem[A+1]} on out_data with out_valid high for exactly one cycle, PC += 3, and leaves the flags unchanged.
- R7: Load, store and add set flag_zero when the register value is 0 and flag_neg when its bit 15 is 1. Other instructions leave both flags unchanged.
- R8: Opcode 3 (call) saves PC+3 in the single return register and jumps to A. Opcode 5 (return) loads PC from the return register, so a nested call overwrites the earlier return address.
- R9: Opcode 6 (jump if zero) sets PC = A when flag_zero is 1 and PC += 3 otherwise. Opcode 7 (jump) always sets PC = A.
- R10: Opcode 8 (halt) raises halted, leaves error low, and the core makes no memory access afterwards. Halted stays high until reset.
- R11: Opcodes 9 to 15 raise both halted and error. Nothing after them runs and no memory access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Byte address of the current memory access |
| mem_rd | output | 1 | Read request; data appears on mem_rdata one cycle later |
| mem_wr | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data byte, one cycle after mem_rd |
| out_data | output | 16 | Word produced by the output instruction |
| out_valid | output | 1 | One-cycle strobe qualifying out_data |
| flag_zero | output | 1 | Zero condition flag |
| flag_neg | output | 1 | Negative condition flag |
| halted | output | 1 | Core has stopped (halt or illegal opcode) |
| error | output | 1 | Core stopped on an illegal opcode |

## Verification
The assertions assume that mem_rdata returns the byte stored at the address requested one cycle earlier, and that reset is held high from time zero for at least one clock edge. The bench has a byte-array memory model that meets this timing exactly. It places every program and data word below address 0x400, so the model never aliases an address. Each program ends in a halt or an illegal opcode, and its control flow is arranged so that it always reaches that end.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_EMIT  = 4'd2,
    OP_CALL  = 4'd3,
    OP_ADD   = 4'd4,
    OP_RET   = 4'd5,
    OP_JZ    = 4'd6,
    OP_JMP   = 4'd7,
    OP_HALT  = 4'd8
  } op_e;

  localparam int unsigned OPC_W = 4;

  typedef enum logic [3:0] {
    ST_F0,
    ST_F1,
    ST_F2,
    ST_DEC,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_WR0,
    ST_WR1,
    ST_STOP
  } state_e;

endpackage

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned WORD_W   = 16,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (we && (idx == IDX_W'(g))) begin
        regs_q[g] <= wdata;
      end
    end
  end

  assign rdata = regs_q[idx];

endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu
  import tcpu_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  op_e               op,
  input  logic [WORD_W-1:0] reg_val,
  input  logic [WORD_W-1:0] mem_word,
  output logic [WORD_W-1:0] result,
  output logic              res_zero,
  output logic              res_neg,
  output logic              reg_we
);

  always_comb begin
    result = reg_val;
    reg_we = 1'b0;
    unique case (op)
      OP_LOAD: begin
        result = mem_word;
        reg_we = 1'b1;
      end
      OP_ADD: begin
        result = reg_val + mem_word;
        reg_we = 1'b1;
      end
      default: begin
        result = reg_val;
        reg_we = 1'b0;
      end
    endcase
  end

  assign res_zero = (result == '0);
  assign res_neg  = result[WORD_W-1];

endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned NUM_REGS   = 4,
  parameter int unsigned START_ADDR = 16,
  localparam int unsigned WORD_W    = 2 * BYTE_W,
  localparam int unsigned ADDR_W    = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              flag_zero,
  output logic              flag_neg,
  output logic              halted,
  output logic              error
);

  localparam int unsigned IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned INSTR_LEN = 3;

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] ret_q;
  logic [BYTE_W-1:0] ir_q;
  logic [BYTE_W-1:0] ahi_q;
  logic [ADDR_W-1:0] ea_q;
  logic [BYTE_W-1:0] dhi_q;
  logic              zf_q;
  logic              nf_q;
  logic [WORD_W-1:0] out_data_q;
  logic              out_valid_q;
  logic              halted_q;
  logic              error_q;

  op_e               op;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] operand;
  logic [WORD_W-1:0] rd_word;
  logic [ADDR_W-1:0] pc_step;
  logic [WORD_W-1:0] rf_rdata;
  logic [WORD_W-1:0] alu_result;
  logic              alu_zero;
  logic              alu_neg;
  logic              alu_we;
  logic              rf_we;
  logic              unused_ir;

  assign op      = op_e'(ir_q[BYTE_W-1 -: OPC_W]);
  assign idx     = ir_q[IDX_W-1:0];
  assign operand = {ahi_q, mem_rdata};
  assign rd_word = {dhi_q, mem_rdata};
  assign pc_step = pc_q + ADDR_W'(INSTR_LEN);

  // bits between the index field and the opcode field carry no meaning
  assign unused_ir = ^ir_q;

  assign rf_we = (state_q == ST_RD2) && alu_we;

  tcpu_regfile #(
    .NUM_REGS (NUM_REGS),
    .WORD_W   (WORD_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .idx   (idx),
    .wdata (alu_result),
    .rdata (rf_rdata)
  );

  tcpu_alu #(
    .WORD_W (WORD_W)
  ) u_alu (
    .op       (op),
    .reg_val  (rf_rdata),
    .mem_word (rd_word),
    .result   (alu_result),
    .res_zero (alu_zero),
    .res_neg  (alu_neg),
    .reg_we   (alu_we)
  );

  // memory request decode from the registered state
  always_comb begin
    mem_addr  = pc_q;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_F0: begin
        mem_addr = pc_q;
        mem_rd   = 1'b1;
      end
      ST_F1: begin
        mem_addr = pc_q + ADDR_W'(1);
        mem_rd   = 1'b1;
      end
      ST_F2: begin
        mem_addr = pc_q + ADDR_W'(2);
        mem_rd   = 1'b1;
      end
      ST_RD0: begin
        mem_addr = ea_q;
        mem_rd   = 1'b1;
      end
      ST_RD1: begin
        mem_addr = ea_q + ADDR_W'(1);
        mem_rd   = 1'b1;
      end
      ST_WR0: begin
        mem_addr  = ea_q;
        mem_wr    = 1'b1;
        mem_wdata = rf_rdata[WORD_W-1 -: BYTE_W];
      end
      ST_WR1: begin
        mem_addr  = ea_q + ADDR_W'(1);
        mem_wr    = 1'b1;
        mem_wdata = rf_rdata[BYTE_W-1:0];
      end
      default: begin
        mem_addr = pc_q;
      end
    endcase
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_F0;
      pc_q        <= ADDR_W'(START_ADDR);
      ret_q       <= '0;
      ir_q        <= '0;
      ahi_q       <= '0;
      ea_q        <= '0;
      dhi_q       <= '0;
      zf_q        <= 1'b0;
      nf_q        <= 1'b0;
      out_data_q  <= '0;
      out_valid_q <= 1'b0;
      halted_q    <= 1'b0;
      error_q     <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      unique case (state_q)
        ST_F0: state_q <= ST_F1;
        ST_F1: begin
          ir_q    <= mem_rdata;
          state_q <= ST_F2;
        end
        ST_F2: begin
          ahi_q   <= mem_rdata;
          state_q <= ST_DEC;
        end
        ST_DEC: begin
          ea_q <= operand;
          unique case (op)
            OP_LOAD, OP_ADD, OP_EMIT: state_q <= ST_RD0;
            OP_STORE: state_q <= ST_WR0;
            OP_CALL: begin
              ret_q   <= pc_step;
              pc_q    <= operand;
              state_q <= ST_F0;
            end
            OP_RET: begin
              pc_q    <= ret_q;
              state_q <= ST_F0;
            end
            OP_JZ: begin
              pc_q    <= zf_q ? operand : pc_step;
              state_q <= ST_F0;
            end
            OP_JMP: begin
              pc_q    <= operand;
              state_q <= ST_F0;
            end
            OP_HALT: begin
              halted_q <= 1'b1;
              state_q  <= ST_STOP;
            end
            default: begin
              halted_q <= 1'b1;
              error_q  <= 1'b1;
              state_q  <= ST_STOP;
            end
          endcase
        end
        ST_RD0: state_q <= ST_RD1;
        ST_RD1: begin
          dhi_q   <= mem_rdata;
          state_q <= ST_RD2;
        end
        ST_RD2: begin
          if (op == OP_EMIT) begin
            out_data_q  <= rd_word;
            out_valid_q <= 1'b1;
          end else begin
            zf_q <= alu_zero;
            nf_q <= alu_neg;
          end
          pc_q    <= pc_step;
          state_q <= ST_F0;
        end
        ST_WR0: state_q <= ST_WR1;
        ST_WR1: begin
          zf_q    <= alu_zero;
          nf_q    <= alu_neg;
          pc_q    <= pc_step;
          state_q <= ST_F0;
        end
        ST_STOP: state_q <= ST_STOP;
        default: state_q <= ST_STOP;
      endcase
    end
  end

  assign out_data  = out_data_q;
  assign out_valid = out_valid_q;
  assign flag_zero = zf_q;
  assign flag_neg  = nf_q;
  assign halted    = halted_q;
  assign error     = error_q;

endmodule

// File: rtl/tcpu_checker.sv
module tcpu_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [BYTE_W-1:0] mem_wdata,
  input logic [BYTE_W-1:0] mem_rdata,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid,
  input logic              flag_zero,
  input logic              flag_neg,
  input logic              halted,
  input logic              error
);

  logic unused_chk;
  assign unused_chk = ^{mem_wdata, mem_rdata, out_data};

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R2

  AST_STORE_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |=> (mem_wr && (mem_addr == $past(mem_addr) + WORD_W'(1)))); // R4

  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |=> !mem_wr); // R4

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R6

  AST_OUT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $stable({flag_zero, flag_neg})); // R6

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R10

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr && !out_valid)); // R10

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
    error |-> halted); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    error |=> error); // R11

endmodule

bind tcpu_core tcpu_checker #(
  .WORD_W (2 * BYTE_W),
  .BYTE_W (BYTE_W)
) u_chk (.*);

// File: tb/tb_tcpu_core.sv
module tb_tcpu_core;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [15:0] out_data;
  logic        out_valid;
  logic        flag_zero;
  logic        flag_neg;
  logic        halted;
  logic        error;

  int tests_run = 0;
  int tests_failed = 0;

  logic [7:0]  mem [MEM_BYTES];
  logic [15:0] outs [16];
  int          out_n = 0;
  int          quiet_viol = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tcpu_core dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .out_data  (out_data),
    .out_valid (out_valid),
    .flag_zero (flag_zero),
    .flag_neg  (flag_neg),
    .halted    (halted),
    .error     (error)
  );

  // memory model: synchronous, one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] = mem_wdata;
    if (!rst && out_valid) begin
      if (out_n < 16) outs[out_n] = out_data;
      out_n = out_n + 1;
    end
    if (!rst && halted && (mem_rd || mem_wr)) quiet_viol = quiet_viol + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'hAA;
  endtask

  task automatic put_ins(input int a, input int op, input int idx_byte, input int ea);
    mem[a]     = 8'((op << 4) | idx_byte);
    mem[a + 1] = 8'(ea >> 8);
    mem[a + 2] = 8'(ea & 8'hFF);
  endtask

  task automatic put_word(input int a, input int w);
    mem[a]     = 8'(w >> 8);
    mem[a + 1] = 8'(w & 8'hFF);
  endtask

  function automatic int get_word(input int a);
    return {16'd0, mem[a], mem[a + 1]};
  endfunction

  task automatic hold_reset();
    rst = 1'b1;
    out_n = 0;
    quiet_viol = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_to_halt(input string req);
    rst = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    chk(halted == 1'b1, {req, " run reaches halt"}, halted, 1);
  endtask

  // R1 R2 R10: reset state, fetch order, plain halt
  task automatic t_reset_fetch();
    clear_mem();
    put_ins(16'h10, 8, 0, 0);
    hold_reset();
    chk(mem_rd && mem_addr == 16'h0010, "R1 first fetch address", mem_addr, 16'h0010);
    chk(!halted && !error && !out_valid, "R1 status low in reset", {halted, error, out_valid}, 0);
    chk(!flag_zero && !flag_neg, "R1 flags clear", {flag_zero, flag_neg}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_rd && mem_addr == 16'h0011, "R2 second fetch byte", mem_addr, 16'h0011);
    @(negedge clk);
    chk(mem_rd && mem_addr == 16'h0012, "R2 third fetch byte", mem_addr, 16'h0012);
    run_to_halt("R10");
    chk(error == 1'b0, "R10 halt without error", error, 0);
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R10 halt sticky", halted, 1);
    chk(quiet_viol == 0, "R10 no access after halt", quiet_viol, 0);
  endtask

  // R3 R4 R6 R7: load, output, store with negative value
  task automatic t_load_out_store();
    clear_mem();
    put_word(16'h100, 16'h8001);
    put_ins(16'h10, 0, 1, 16'h100);
    put_ins(16'h13, 2, 0, 16'h100);
    put_ins(16'h16, 1, 1, 16'h200);
    put_ins(16'h19, 8, 0, 0);
    hold_reset();
    run_to_halt("R3");
    chk(out_n == 1, "R6 one output strobe", out_n, 1);
    chk(outs[0] == 16'h8001, "R3 R6 loaded word output", outs[0], 16'h8001);
    chk(mem[16'h200] == 8'h80, "R4 high byte at A", mem[16'h200], 8'h80);
    chk(mem[16'h201] == 8'h01, "R4 low byte at A+1", mem[16'h201], 8'h01);
    chk(flag_neg == 1'b1 && flag_zero == 1'b0, "R7 negative flag", {flag_zero, flag_neg}, 1);
  endtask

  // R5 R7 R9: add wraps to zero, taken jump-if-zero
  task automatic t_add_wrap_jz();
    clear_mem();
    put_word(16'h100, 16'hFFFF);
    put_word(16'h102, 16'h0001);
    put_word(16'h104, 16'h1234);
    put_word(16'h106, 16'hDEAD);
    put_ins(16'h10, 0, 2, 16'h100);
    put_ins(16'h13, 4, 2, 16'h102);
    put_ins(16'h16, 1, 2, 16'h200);
    put_ins(16'h19, 6, 0, 16'h40);
    put_ins(16'h1C, 2, 0, 16'h106);
    put_ins(16'h1F, 8, 0, 0);
    put_ins(16'h40, 2, 0, 16'h104);
    put_ins(16'h43, 8, 0, 0);
    hold_reset();
    run_to_halt("R5");
    chk(get_word(16'h200) == 0, "R5 add wraps modulo 2^16", get_word(16'h200), 0);
    chk(flag_zero == 1'b1 && flag_neg == 1'b0, "R7 zero flag after store", {flag_zero, flag_neg}, 2);
    chk(out_n == 1 && outs[0] == 16'h1234, "R9 jump-if-zero taken", outs[0], 16'h1234);
  endtask

  // R9: jump-if-zero falls through, plain jump
  task automatic t_jz_not_taken();
    clear_mem();
    put_word(16'h100, 16'h0005);
    put_word(16'h104, 16'h1234);
    put_word(16'h106, 16'hDEAD);
    put_ins(16'h10, 0, 0, 16'h100);
    put_ins(16'h13, 6, 0, 16'h40);
    put_ins(16'h16, 2, 0, 16'h104);
    put_ins(16'h19, 7, 0, 16'h60);
    put_ins(16'h1C, 2, 0, 16'h106);
    put_ins(16'h1F, 8, 0, 0);
    put_ins(16'h40, 2, 0, 16'h106);
    put_ins(16'h43, 8, 0, 0);
    put_ins(16'h60, 8, 0, 0);
    hold_reset();
    run_to_halt("R9");
    chk(out_n == 1, "R9 only fall-through output", out_n, 1);
    chk(outs[0] == 16'h1234, "R9 fall-through word", outs[0], 16'h1234);
    chk(flag_zero == 1'b0, "R9 jumps keep flags", flag_zero, 0);
  endtask

  // R8: single return register, nested call overwrites
  task automatic t_call_ret();
    clear_mem();
    put_word(16'h104, 16'h1111);
    put_word(16'h106, 16'h2222);
    put_word(16'h108, 16'h4444);
    put_ins(16'h10, 3, 0, 16'h40);
    put_ins(16'h13, 2, 0, 16'h104);
    put_ins(16'h16, 3, 0, 16'h50);
    put_ins(16'h19, 8, 0, 0);
    put_ins(16'h40, 2, 0, 16'h106);
    put_ins(16'h43, 5, 0, 0);
    put_ins(16'h50, 3, 0, 16'h60);
    put_ins(16'h53, 2, 0, 16'h108);
    put_ins(16'h56, 8, 0, 0);
    put_ins(16'h60, 5, 0, 0);
    hold_reset();
    run_to_halt("R8");
    chk(out_n == 3, "R8 output count", out_n, 3);
    chk(outs[0] == 16'h2222, "R8 call enters subroutine", outs[0], 16'h2222);
    chk(outs[1] == 16'h1111, "R8 return to PC+3", outs[1], 16'h1111);
    chk(outs[2] == 16'h4444, "R8 nested call overwrote return", outs[2], 16'h4444);
  endtask

  // R11: illegal opcode stops with error
  task automatic t_illegal(input int op);
    clear_mem();
    put_word(16'h100, 16'h5555);
    put_word(16'h102, 16'h6666);
    put_ins(16'h10, 2, 0, 16'h100);
    put_ins(16'h13, op, 0, 16'h102);
    put_ins(16'h16, 2, 0, 16'h102);
    put_ins(16'h19, 8, 0, 0);
    hold_reset();
    run_to_halt("R11");
    chk(error == 1'b1, "R11 error raised", error, 1);
    chk(out_n == 1 && outs[0] == 16'h5555, "R11 nothing runs after", out_n, 1);
    repeat (10) @(negedge clk);
    chk(quiet_viol == 0 && halted, "R11 no access after error", quiet_viol, 0);
  endtask

  // R2 R5: register index field, ignored bits [3:2], add without wrap
  task automatic t_reg_index();
    clear_mem();
    put_word(16'h100, 16'h1111);
    put_word(16'h102, 16'h2222);
    put_word(16'h104, 16'h0111);
    put_ins(16'h10, 0, 8'h0C, 16'h100);
    put_ins(16'h13, 0, 8'h03, 16'h102);
    put_ins(16'h16, 4, 8'h0C, 16'h104);
    put_ins(16'h19, 1, 8'h0C, 16'h200);
    put_ins(16'h1C, 1, 8'h03, 16'h202);
    put_ins(16'h1F, 8, 0, 0);
    hold_reset();
    run_to_halt("R2");
    chk(get_word(16'h200) == 16'h1222, "R2 R5 register 0 sum", get_word(16'h200), 16'h1222);
    chk(get_word(16'h202) == 16'h2222, "R2 register 3 kept apart", get_word(16'h202), 16'h2222);
    chk(!flag_zero && !flag_neg, "R7 flags from last store", {flag_zero, flag_neg}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    clear_mem();
    mem_rdata = 8'h00;
    t_reset_fetch();
    t_load_out_store();
    t_add_wrap_jz();
    t_jz_not_taken();
    t_call_ret();
    t_illegal(9);
    t_illegal(15);
    t_reg_index();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule